// File: doc/BRIEF.md
# Serial Audio Codec Control Register Bank

This block is the register file that holds every control setting of a serial audio codec. The settings fall into two groups. The setup group covers sample format, rate, channel count, clock source, frame length, master/slave role, loopback and the parallel-output bits. The run group covers output attenuation, muting, input select, input gain and mix attenuation. A decoded control-word interface writes both groups through eight-bit images at fixed addresses. The D/C input selects the mode: low is setup (control) mode, high is run (data) mode.

The block has two reset levels. A reset, or a power-down request, loads the default value into every field. When D/C rises from setup to run mode, only the run group goes back to its defaults. Setup writes are kept, and the parallel-output bits are kept. A run-group write that arrives in the transition cycle overrides that reload for its own address. While in run mode, writes to setup addresses have no effect. The block also registers the external parallel-I/O pins every cycle, and it drives the output enable of the serial pins from the mode.

Top module: `codec_ctrl_regs`

## Requirements
- R1: After reset every field holds its default. As address images (addr: value) the defaults are 0:0x3F, 1:0x3F, 2:0x00, 3:0xF0, 4:0x02, 5:0x12, 6:0x63. This puts the block in slave mode (master_o=0) with the external bit clock as source (clk_src_o=0).
- R2: When pwrdn_i is high at a clock edge, all fields hold their defaults after the second edge. This load wins over any write or mode event in that cycle.
- R3: In setup mode (dc_i low) a write updates its address image. The bit layouts are: addr0 {out_mute[1:0], att_l[5:0]}; addr1 {spk_mute, in_sel, att_r[5:0]}; addr2 {gain_l[3:0], gain_r[3:0]}; addr3 {mix_att[3:0] in [7:4], ovr in [0]}; addr4 {cal_en, rate_sel[2:0], stereo, fmt[1:0], chain_sel}; addr5 {clk_src[2:0], frame_len[1:0], master, sdo_off, lpbk_en}; addr6 {lpbk_mode in [7], adc_invalid in [6], dc_bit in [5], pio_out in [1:0]}. Unlisted bits read 0.
- R4: In run mode, writes to addresses 4 to 6 are ignored. Writes to addresses 0 to 3 still take effect.
- R5: dc_i rises at edge k. After edge k+1, addresses 0 to 3 hold their defaults. Addresses 4 to 6, pio_out included, keep their values.
- R6: pio_in_o always equals the value pio_pins_i had at the previous clock edge, including across mode changes.
- R7: A run-group write presented in the transition cycle (between edges k and k+1) takes effect instead of the reload for that address. The other run-group addresses are still reloaded.
- R8: serial_oe_o follows dc_i with a latency of exactly two clock edges. It therefore drops within three bit-clock cycles of D/C going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwrdn_i | input | 1 | Power-down request (full default load) |
| dc_i | input | 1 | Mode select: 0 setup, 1 run |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data image |
| pio_pins_i | input | 2 | External parallel-I/O pins |
| pio_in_o | output | 2 | Registered pin sample |
| serial_oe_o | output | 1 | Serial pin output enable |
| out_mute_o | output | 2 | Line output mute |
| att_l_o | output | 6 | Left output attenuation |
| spk_mute_o | output | 1 | Speaker mute |
| in_sel_o | output | 1 | Input select |
| att_r_o | output | 6 | Right output attenuation |
| gain_l_o | output | 4 | Left input gain |
| gain_r_o | output | 4 | Right input gain |
| mix_att_o | output | 4 | Mix attenuation |
| ovr_o | output | 1 | Overrange field |
| cal_en_o | output | 1 | Calibration enable |
| rate_sel_o | output | 3 | Sample rate select |
| stereo_o | output | 1 | Stereo enable |
| fmt_o | output | 2 | Data format |
| chain_sel_o | output | 1 | Chain slot select |
| clk_src_o | output | 3 | Clock source select |
| frame_len_o | output | 2 | Frame length select |
| master_o | output | 1 | Master role |
| sdo_off_o | output | 1 | Serial output disable |
| lpbk_en_o | output | 1 | Loopback enable |
| lpbk_mode_o | output | 1 | Loopback type |
| adc_invalid_o | output | 1 | ADC data invalid |
| dc_bit_o | output | 1 | Stored D/C field |
| pio_out_o | output | 2 | Parallel-output field |

## Verification
Random writes in setup mode, with random addresses and data, show that every image and its mask are decoded. Random writes in run mode show that setup addresses are blocked while run addresses still work. Directed mode changes after non-default writes show that the reload covers only the run group and leaves pio_out alone. A write placed in the transition cycle shows that the write wins over the reload for its own address only. A power-down that arrives together with a write shows that the full load has the highest priority. Random pin values across mode edges pin down the one-cycle latency of the pin sample.

// File: rtl/codec_ctrl_pkg.sv
package codec_ctrl_pkg;
  localparam int unsigned REG_W = 8;

  localparam int unsigned ADR_OUTL = 0;
  localparam int unsigned ADR_OUTR = 1;
  localparam int unsigned ADR_GAIN = 2;
  localparam int unsigned ADR_MIX  = 3;
  localparam int unsigned ADR_FMT  = 4;
  localparam int unsigned ADR_CLK  = 5;
  localparam int unsigned ADR_MISC = 6;

  typedef struct packed {
    logic [1:0] out_mute;
    logic [5:0] att_l;
    logic       spk_mute;
    logic       in_sel;
    logic [5:0] att_r;
    logic [3:0] gain_l;
    logic [3:0] gain_r;
    logic [3:0] mix_att;
    logic       ovr;
  } run_fields_t;

  typedef struct packed {
    logic       cal_en;
    logic [2:0] rate_sel;
    logic       stereo;
    logic [1:0] fmt;
    logic       chain_sel;
    logic [2:0] clk_src;
    logic [1:0] frame_len;
    logic       master;
    logic       sdo_off;
    logic       lpbk_en;
    logic       lpbk_mode;
    logic       adc_invalid;
    logic       dc_bit;
    logic [1:0] pio_out;
  } setup_fields_t;

  localparam run_fields_t RUN_DEF = '{
    out_mute: 2'd0, att_l: 6'd63, spk_mute: 1'b0, in_sel: 1'b0, att_r: 6'd63,
    gain_l: 4'd0, gain_r: 4'd0, mix_att: 4'd15, ovr: 1'b0};

  localparam setup_fields_t SETUP_DEF = '{
    cal_en: 1'b0, rate_sel: 3'd0, stereo: 1'b0, fmt: 2'd1, chain_sel: 1'b0,
    clk_src: 3'd0, frame_len: 2'd2, master: 1'b0, sdo_off: 1'b1, lpbk_en: 1'b0,
    lpbk_mode: 1'b0, adc_invalid: 1'b1, dc_bit: 1'b1, pio_out: 2'd3};
endpackage

// File: rtl/codec_mode_track.sv
module codec_mode_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dc_i,
  input  logic pwrdn_i,
  output logic run_mode_o,
  output logic enter_run_o,
  output logic load_all_o,
  output logic serial_oe_o
);
  logic dc_q, dc_qq, pd_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dc_q  <= 1'b0;
      dc_qq <= 1'b0;
      pd_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      dc_q  <= dc_i;
      dc_qq <= dc_q;
      pd_q  <= pwrdn_i;
      oe_q  <= dc_q;
    end
  end

  assign run_mode_o  = dc_q;
  assign enter_run_o = dc_q & ~dc_qq;
  assign load_all_o  = pd_q;
  assign serial_oe_o = oe_q;

  // R8
  oe_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dc_i |-> ##2 !serial_oe_o);
  // R5
  enter_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_run_o |=> !enter_run_o);
endmodule

// File: rtl/codec_run_bank.sv
module codec_run_bank
  import codec_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_all_i,
  input  logic              reload_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output run_fields_t       q_o
);
  run_fields_t q, nxt;

  always_comb begin
    nxt = q;
    if (reload_i) nxt = RUN_DEF;
    // a write in the reload cycle overrides its own address
    if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_W'(ADR_OUTL): {nxt.out_mute, nxt.att_l} = wr_data_i;
        ADDR_W'(ADR_OUTR): {nxt.spk_mute, nxt.in_sel, nxt.att_r} = wr_data_i;
        ADDR_W'(ADR_GAIN): {nxt.gain_l, nxt.gain_r} = wr_data_i;
        ADDR_W'(ADR_MIX): begin
          nxt.mix_att = wr_data_i[7:4];
          nxt.ovr     = wr_data_i[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q <= RUN_DEF;
    else if (load_all_i) q <= RUN_DEF;
    else                 q <= nxt;
  end

  assign q_o = q;

  // R2
  run_full_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_all_i |=> q_o == RUN_DEF);
  // R5
  run_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i && !load_all_i && !(wr_en_i && wr_addr_i == ADDR_W'(ADR_GAIN))
    |=> q_o.gain_l == RUN_DEF.gain_l && q_o.gain_r == RUN_DEF.gain_r);
endmodule

// File: rtl/codec_setup_bank.sv
module codec_setup_bank
  import codec_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_all_i,
  input  logic              run_mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output setup_fields_t     q_o
);
  setup_fields_t q, nxt;
  logic wr_ok;

  assign wr_ok = wr_en_i & ~run_mode_i;

  always_comb begin
    nxt = q;
    if (wr_ok) begin
      unique case (wr_addr_i)
        ADDR_W'(ADR_FMT):
          {nxt.cal_en, nxt.rate_sel, nxt.stereo, nxt.fmt, nxt.chain_sel} = wr_data_i;
        ADDR_W'(ADR_CLK):
          {nxt.clk_src, nxt.frame_len, nxt.master, nxt.sdo_off, nxt.lpbk_en} = wr_data_i;
        ADDR_W'(ADR_MISC): begin
          nxt.lpbk_mode   = wr_data_i[7];
          nxt.adc_invalid = wr_data_i[6];
          nxt.dc_bit      = wr_data_i[5];
          nxt.pio_out     = wr_data_i[1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q <= SETUP_DEF;
    else if (load_all_i) q <= SETUP_DEF;
    else                 q <= nxt;
  end

  assign q_o = q;

  // R2
  setup_full_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_all_i |=> q_o == SETUP_DEF);
  // R4
  setup_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_mode_i && !load_all_i |=> $stable(q_o));
endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
  import codec_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned PIO_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrdn_i,
  input  logic              dc_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [PIO_W-1:0]  pio_pins_i,
  output logic [PIO_W-1:0]  pio_in_o,
  output logic              serial_oe_o,
  output logic [1:0]        out_mute_o,
  output logic [5:0]        att_l_o,
  output logic              spk_mute_o,
  output logic              in_sel_o,
  output logic [5:0]        att_r_o,
  output logic [3:0]        gain_l_o,
  output logic [3:0]        gain_r_o,
  output logic [3:0]        mix_att_o,
  output logic              ovr_o,
  output logic              cal_en_o,
  output logic [2:0]        rate_sel_o,
  output logic              stereo_o,
  output logic [1:0]        fmt_o,
  output logic              chain_sel_o,
  output logic [2:0]        clk_src_o,
  output logic [1:0]        frame_len_o,
  output logic              master_o,
  output logic              sdo_off_o,
  output logic              lpbk_en_o,
  output logic              lpbk_mode_o,
  output logic              adc_invalid_o,
  output logic              dc_bit_o,
  output logic [1:0]        pio_out_o
);
  logic run_mode, enter_run, load_all;
  run_fields_t   run_q;
  setup_fields_t setup_q;
  logic [PIO_W-1:0] pio_q;

  codec_mode_track u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dc_i        (dc_i),
    .pwrdn_i     (pwrdn_i),
    .run_mode_o  (run_mode),
    .enter_run_o (enter_run),
    .load_all_o  (load_all),
    .serial_oe_o (serial_oe_o)
  );

  codec_run_bank #(.ADDR_W(ADDR_W)) u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_all_i (load_all),
    .reload_i   (enter_run),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .q_o        (run_q)
  );

  codec_setup_bank #(.ADDR_W(ADDR_W)) u_setup (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_all_i (load_all),
    .run_mode_i (run_mode),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .q_o        (setup_q)
  );

  // pin sample runs regardless of mode or load events
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pio_q <= '0;
    else         pio_q <= pio_pins_i;
  end
  assign pio_in_o = pio_q;

  assign out_mute_o    = run_q.out_mute;
  assign att_l_o       = run_q.att_l;
  assign spk_mute_o    = run_q.spk_mute;
  assign in_sel_o      = run_q.in_sel;
  assign att_r_o       = run_q.att_r;
  assign gain_l_o      = run_q.gain_l;
  assign gain_r_o      = run_q.gain_r;
  assign mix_att_o     = run_q.mix_att;
  assign ovr_o         = run_q.ovr;
  assign cal_en_o      = setup_q.cal_en;
  assign rate_sel_o    = setup_q.rate_sel;
  assign stereo_o      = setup_q.stereo;
  assign fmt_o         = setup_q.fmt;
  assign chain_sel_o   = setup_q.chain_sel;
  assign clk_src_o     = setup_q.clk_src;
  assign frame_len_o   = setup_q.frame_len;
  assign master_o      = setup_q.master;
  assign sdo_off_o     = setup_q.sdo_off;
  assign lpbk_en_o     = setup_q.lpbk_en;
  assign lpbk_mode_o   = setup_q.lpbk_mode;
  assign adc_invalid_o = setup_q.adc_invalid;
  assign dc_bit_o      = setup_q.dc_bit;
  assign pio_out_o     = setup_q.pio_out;

  // R6
  pio_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pio_in_o == $past(pio_pins_i));
  // R5
  pio_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_run && !load_all |=> $stable(pio_out_o));
endmodule

// File: tb/codec_ctrl_regs_bench.sv
module codec_ctrl_regs_bench;
  localparam int unsigned ADDR_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwrdn = 1'b0, dc = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] pins = '0;
  logic [1:0] pio_in, out_mute, fmt, frame_len, pio_out;
  logic serial_oe, spk_mute, in_sel, ovr, cal_en, stereo, chain_sel, master;
  logic sdo_off, lpbk_en, lpbk_mode, adc_invalid, dc_bit;
  logic [5:0] att_l, att_r;
  logic [3:0] gain_l, gain_r, mix_att;
  logic [2:0] rate_sel, clk_src;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_img [7];

  always #2.5 clk = ~clk;

  codec_ctrl_regs #(.ADDR_W(ADDR_W)) u_codec_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_ni), .pwrdn_i(pwrdn), .dc_i(dc),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pio_pins_i(pins), .pio_in_o(pio_in), .serial_oe_o(serial_oe),
    .out_mute_o(out_mute), .att_l_o(att_l), .spk_mute_o(spk_mute),
    .in_sel_o(in_sel), .att_r_o(att_r), .gain_l_o(gain_l), .gain_r_o(gain_r),
    .mix_att_o(mix_att), .ovr_o(ovr), .cal_en_o(cal_en), .rate_sel_o(rate_sel),
    .stereo_o(stereo), .fmt_o(fmt), .chain_sel_o(chain_sel), .clk_src_o(clk_src),
    .frame_len_o(frame_len), .master_o(master), .sdo_off_o(sdo_off),
    .lpbk_en_o(lpbk_en), .lpbk_mode_o(lpbk_mode), .adc_invalid_o(adc_invalid),
    .dc_bit_o(dc_bit), .pio_out_o(pio_out));

  function automatic logic [7:0] def_img(int a);
    case (a)
      0: return 8'h3F;  1: return 8'h3F;  2: return 8'h00;  3: return 8'hF0;
      4: return 8'h02;  5: return 8'h12;  6: return 8'h63;  default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] mask_img(int a);
    case (a)
      3: return 8'hF1;  6: return 8'hE3;  7: return 8'h00;  default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] dut_img(int a);
    case (a)
      0: return {out_mute, att_l};
      1: return {spk_mute, in_sel, att_r};
      2: return {gain_l, gain_r};
      3: return {mix_att, 3'b000, ovr};
      4: return {cal_en, rate_sel, stereo, fmt, chain_sel};
      5: return {clk_src, frame_len, master, sdo_off, lpbk_en};
      6: return {lpbk_mode, adc_invalid, dc_bit, 3'b000, pio_out};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int a = 0; a < 7; a++) check($sformatf("%s addr%0d", req, a), dut_img(a), exp_img[a]);
  endtask

  task automatic load_defaults();
    for (int a = 0; a < 7; a++) exp_img[a] = def_img(a);
  endtask

  // one write, sampled one edge later; model applies the mode rule
  task automatic do_write(int a, logic [7:0] d, logic run);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 7 && !(run && a >= 4)) exp_img[a] = d & mask_img(a);
  endtask

  // watchdog
  initial begin
    #1ms;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0DE5EED));
    load_defaults();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1
    check_all("R1");
    check("R1 master", master, 0);
    check("R1 clk_src", clk_src, 0);
    check("R8 oe in setup", serial_oe, 0);

    // R3: random setup-mode writes
    for (int i = 0; i < 60; i++) begin
      int a = $urandom_range(0, 7);
      do_write(a, 8'($urandom), 1'b0);
      if (a < 7) check($sformatf("R3 addr%0d", a), dut_img(a), exp_img[a]);
    end
    do_write(0, 8'h15, 1'b0); do_write(2, 8'h7A, 1'b0);
    do_write(3, 8'h31, 1'b0); do_write(6, 8'h80, 1'b0);
    check_all("R3");

    // R5: setup -> run reload
    dc = 1'b1;
    @(negedge clk);
    check("R8 oe latency 1", serial_oe, 0);
    @(negedge clk);
    for (int a = 0; a < 4; a++) exp_img[a] = def_img(a);
    check_all("R5");
    check("R5 pio_out kept", pio_out, 0);
    check("R8 oe rises", serial_oe, 1);

    // R4: random run-mode writes
    for (int i = 0; i < 40; i++) begin
      int a = $urandom_range(0, 6);
      do_write(a, 8'($urandom), 1'b1);
      check($sformatf("R4 addr%0d", a), dut_img(a), exp_img[a]);
    end
    check_all("R4");

    // R8: drop back to setup
    dc = 1'b0;
    @(negedge clk);
    check("R8 oe holds 1 edge", serial_oe, 1);
    @(negedge clk);
    check("R8 oe drops", serial_oe, 0);

    // R7: write in the transition cycle beats the reload
    do_write(0, 8'h11, 1'b0); do_write(2, 8'h99, 1'b0); do_write(1, 8'hC0, 1'b0);
    dc = 1'b1;
    @(negedge clk);
    do_write(0, 8'hA5, 1'b1);
    exp_img[1] = def_img(1); exp_img[2] = def_img(2); exp_img[3] = def_img(3);
    check("R7 written addr0", dut_img(0), 8'hA5);
    check("R7 addr1 reloaded", dut_img(1), def_img(1));
    check("R7 addr2 reloaded", dut_img(2), def_img(2));

    // R2: power-down with a coincident write
    dc = 1'b0;
    repeat (2) @(negedge clk);
    do_write(5, 8'hFF, 1'b0); do_write(1, 8'h05, 1'b0);
    pwrdn = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0;
    load_defaults();
    check_all("R2");
    pwrdn = 1'b0;
    @(negedge clk);

    // R6: pin sample across mode edges
    for (int i = 0; i < 30; i++) begin
      logic [1:0] p = 2'($urandom);
      pins = p;
      if (i % 7 == 3) dc = ~dc;
      @(negedge clk);
      check("R6 pin sample", pio_in, p);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule